// File: doc/BRIEF.md
# Automatic Status Polling Matcher

This block repeatedly reads a status word from an external memory and stops when the word shows a chosen bit pattern. Each read goes out as a request to a command engine outside the block. The engine answers with a one-cycle done pulse and the returned data. The status word is 1 to 4 bytes long. A mask picks the bits that take part, and a match value gives the wanted level of each bit. The comparison runs in either AND mode or OR mode.

Between reads the block stays quiet for a programmable number of cycles. A hit always sets a sticky match flag. If auto-stop is selected, the first hit also ends the poll loop. Otherwise the loop runs until an abort.

The block keeps the most recent raw status word, with no mask applied. A read flag shows that a new word has arrived, and software clears it by reading that word. Configuration inputs are used live and must be held stable while `busy` is high.

Top module: `status_poll_matcher`

## Requirements
- R1: After reset, `busy`, `rd_req`, `match_flag`, `read_flag` and `done_flag` are 0 and `status_word` is zero.
- R2: A `start` pulse while idle raises `rd_req` (and `busy`) on the next cycle. A `start` while busy is ignored and does not shorten the current gap.
- R3: `cfg_len` holds the byte count minus one (0 to 3). Byte k (bits 8k+7..8k) counts only when k <= `cfg_len`. Bytes above the length are zero in `status_word` and are treated as masked out.
- R4: With `cfg_or_mode`=0 (AND), a read is a hit when every bit that is set in the effective mask equals its `cfg_match` bit. An empty effective mask is a hit.
- R5: With `cfg_or_mode`=1 (OR), a read is a hit when at least one bit that is set in the effective mask equals its `cfg_match` bit. An empty effective mask is never a hit.
- R6: After a completed read that does not end polling, `rd_req` stays low for exactly `cfg_interval` cycles before the next request. When `cfg_interval` is 0, `rd_req` stays high with no gap.
- R7: With `cfg_auto_stop`=1, a hit ends polling, so `busy` is 0 on the next cycle. With `cfg_auto_stop`=0, polling continues after a hit.
- R8: `match_flag` is set by a hit and stays set until a `clr_match` pulse. A hit in the same cycle as `clr_match` wins.
- R9: `read_flag` is set by every completed read (`rd_req` and `rd_done` high together) and cleared by a `data_rd` pulse. Setting wins over clearing. A `rd_done` while idle is ignored.
- R10: `status_word` holds the last received bytes without the mask applied.
- R11: An abort during the gap ends polling on the next cycle. An abort while a request is outstanding ends polling on the cycle after that read's `rd_done`. Both cases set `done_flag`. An abort while idle has no effect.
- R12: `done_flag` is set whenever polling ends. It is cleared by `clr_done` or by a new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin polling (pulse) |
| abort | input | 1 | End polling (pulse) |
| cfg_len | input | 2 | Status byte count minus one |
| cfg_mask | input | 32 | Bit select for comparison |
| cfg_match | input | 32 | Wanted bit levels |
| cfg_or_mode | input | 1 | 0 = AND match, 1 = OR match |
| cfg_auto_stop | input | 1 | Stop on first hit |
| cfg_interval | input | 16 | Idle cycles between reads |
| rd_req | output | 1 | Status read request to command engine |
| rd_done | input | 1 | Read complete pulse |
| rd_data | input | 32 | Returned status bytes |
| data_rd | input | 1 | Software read of status word (clears read flag) |
| clr_match | input | 1 | Clear match flag |
| clr_done | input | 1 | Clear done flag |
| busy | output | 1 | Polling active |
| match_flag | output | 1 | Sticky hit flag |
| read_flag | output | 1 | New status word available |
| done_flag | output | 1 | Polling has ended |
| status_word | output | 32 | Last raw status, length-limited |

## Verification
A sequencer stuck in the wrong state shows up within one cycle. Either `rd_req` fails to rise after `start`, or `busy` stays high after an abort during the gap. A wrong gap counter shows as a low window of the wrong length on `rd_req`, which the bench measures cycle by cycle. Errors in the mask, length or mode logic appear on `match_flag` and on whether `busy` drops, one cycle after the `rd_done` pulse. The vector table covers masks that fall wholly outside the status length, where AND and OR mode must give opposite answers.

// File: rtl/status_poll_matcher.sv
module status_poll_matcher #(
  parameter int BYTES = 4,
  parameter int IVL_W = 16,
  localparam int DW = 8 * BYTES,
  localparam int LW = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [LW-1:0]    cfg_len,
  input  logic [DW-1:0]    cfg_mask,
  input  logic [DW-1:0]    cfg_match,
  input  logic             cfg_or_mode,
  input  logic             cfg_auto_stop,
  input  logic [IVL_W-1:0] cfg_interval,
  output logic             rd_req,
  input  logic             rd_done,
  input  logic [DW-1:0]    rd_data,
  input  logic             data_rd,
  input  logic             clr_match,
  input  logic             clr_done,
  output logic             busy,
  output logic             match_flag,
  output logic             read_flag,
  output logic             done_flag,
  output logic [DW-1:0]    status_word
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;

  state_t           state;
  logic [IVL_W-1:0] cnt;
  logic             abort_pend;
  logic [DW-1:0]    len_mask;
  logic [DW-1:0]    eff_mask;
  logic [DW-1:0]    diff;
  logic             hit;
  logic             got;
  logic             stop_evt;

  for (genvar b = 0; b < BYTES; b++) begin : g_len
    assign len_mask[8*b +: 8] = (b <= int'(cfg_len)) ? 8'hFF : 8'h00;
  end

  assign eff_mask = cfg_mask & len_mask;
  assign diff     = rd_data ^ cfg_match;
  assign hit      = cfg_or_mode ? |(~diff & eff_mask) : ~|(diff & eff_mask);

  assign got      = (state == S_REQ) && rd_done;
  assign stop_evt = (got && (abort || abort_pend || (hit && cfg_auto_stop)))
                 || ((state == S_WAIT) && abort);

  assign busy   = (state != S_IDLE);
  assign rd_req = (state == S_REQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      abort_pend <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          abort_pend <= 1'b0;
          if (start) state <= S_REQ;
        end
        S_REQ: begin
          if (rd_done) begin
            abort_pend <= 1'b0;
            if (stop_evt) begin
              state <= S_IDLE;
            end else if (cfg_interval == '0) begin
              state <= S_REQ;
            end else begin
              state <= S_WAIT;
              cnt   <= cfg_interval;
            end
          end else if (abort) begin
            abort_pend <= 1'b1;
          end
        end
        S_WAIT: begin
          if (abort) state <= S_IDLE;
          else if (cnt <= IVL_W'(1)) state <= S_REQ;
          else cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_word <= '0;
      read_flag   <= 1'b0;
      match_flag  <= 1'b0;
      done_flag   <= 1'b0;
    end else begin
      if (got) status_word <= rd_data & len_mask;
      read_flag  <= got | (read_flag & ~data_rd);
      match_flag <= (got & hit) | (match_flag & ~clr_match);
      done_flag  <= stop_evt | (done_flag & ~clr_done & ~(start & ~busy));
    end
  end

  p_start_launches_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> rd_req);

  p_len_zeroes_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_done && cfg_len == '0) |=> (status_word[DW-1:8] == '0));

  p_gap_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_req && !abort && cnt > IVL_W'(1)) |=> !rd_req);

  p_autostop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_done && cfg_auto_stop && hit) |=> !busy);

  p_match_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !clr_match) |=> match_flag);

  p_read_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_done) |=> read_flag);

  p_abort_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_req && abort) |=> (!busy && done_flag));

  p_end_marks_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);

endmodule

// File: tb/tb_status_poll_matcher.sv
`timescale 1ns/1ps
module tb_status_poll_matcher;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 0, abort = 0, cfg_or_mode = 0, cfg_auto_stop = 0;
  logic [1:0]  cfg_len = 0;
  logic [31:0] cfg_mask = 0, cfg_match = 0, rd_data = 0;
  logic [15:0] cfg_interval = 0;
  logic        rd_done = 0, data_rd = 0, clr_match = 0, clr_done = 0;
  logic        rd_req, busy, match_flag, read_flag, done_flag;
  logic [31:0] status_word;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  status_poll_matcher dut (
    .clk, .rst_n, .start, .abort, .cfg_len, .cfg_mask, .cfg_match,
    .cfg_or_mode, .cfg_auto_stop, .cfg_interval, .rd_req, .rd_done,
    .rd_data, .data_rd, .clr_match, .clr_done, .busy, .match_flag,
    .read_flag, .done_flag, .status_word
  );

  typedef struct packed {
    logic [1:0]  len;
    logic [31:0] mask;
    logic [31:0] match;
    logic        orm;
    logic [31:0] data;
    logic        hit;
    logic [31:0] word;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'd3, 32'hFFFFFFFF, 32'h12345678, 1'b0, 32'h12345678, 1'b1, 32'h12345678},
    '{2'd3, 32'hFFFFFFFF, 32'h12345678, 1'b0, 32'h12345679, 1'b0, 32'h12345679},
    '{2'd0, 32'hFFFFFFFF, 32'h000000A5, 1'b0, 32'hDEADBEA5, 1'b1, 32'h000000A5},
    '{2'd1, 32'h0000FF00, 32'h00003C00, 1'b0, 32'h11223C99, 1'b1, 32'h00003C99},
    '{2'd3, 32'h00000001, 32'h00000001, 1'b1, 32'h00000000, 1'b0, 32'h00000000},
    '{2'd3, 32'h0000000F, 32'h00000005, 1'b1, 32'h00000004, 1'b1, 32'h00000004},
    '{2'd0, 32'hFF000000, 32'h00000000, 1'b1, 32'h00000000, 1'b0, 32'h00000000},
    '{2'd0, 32'hFF000000, 32'hFF000000, 1'b0, 32'h00000000, 1'b1, 32'h00000000},
    '{2'd2, 32'h00FF0000, 32'h00AB0000, 1'b0, 32'h00AB0000, 1'b1, 32'h00AB0000},
    '{2'd1, 32'h00FF0000, 32'h00000000, 1'b1, 32'h00000000, 1'b0, 32'h00000000}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic respond(input logic [31:0] d);
    rd_done = 1'b1;
    rd_data = d;
    step();
    rd_done = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!rd_req && n < 50) begin
      n++;
      step();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int n;
    step();
    step();
    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 rd_req", 32'(rd_req), 32'd0);
    chk("R1 flags", {29'd0, match_flag, read_flag, done_flag}, 32'd0);
    chk("R1 status_word", status_word, 32'd0);
    rst_n = 1'b1;
    step();

    foreach (VECS[i]) begin
      cfg_len = VECS[i].len;
      cfg_mask = VECS[i].mask;
      cfg_match = VECS[i].match;
      cfg_or_mode = VECS[i].orm;
      cfg_auto_stop = 1'b1;
      cfg_interval = 16'd2;
      pulse_start();
      chk("R2 request after start", 32'(rd_req), 32'd1);
      respond(VECS[i].data);
      chk(VECS[i].orm ? "R5 OR match" : "R4 AND match", 32'(match_flag), 32'(VECS[i].hit));
      chk("R3 R10 status word", status_word, VECS[i].word);
      chk("R7 auto-stop", 32'(busy), 32'(!VECS[i].hit));
      if (busy) begin
        abort = 1'b1;
        step();
        abort = 1'b0;
        chk("R11 abort in gap", 32'(busy), 32'd0);
      end
      chk("R12 done set", 32'(done_flag), 32'd1);
      clr_match = 1'b1; clr_done = 1'b1; data_rd = 1'b1;
      step();
      clr_match = 1'b0; clr_done = 1'b0; data_rd = 1'b0;
      chk("R8 match cleared", 32'(match_flag), 32'd0);
    end

    // R6 gap length, no hit, auto-stop off
    cfg_len = 2'd3; cfg_mask = 32'hFFFFFFFF; cfg_match = 32'd0;
    cfg_or_mode = 1'b0; cfg_auto_stop = 1'b0; cfg_interval = 16'd3;
    pulse_start();
    respond(32'd1);
    count_low(n);
    chk("R6 gap of 3", 32'(n), 32'd3);

    // R2 start during gap is ignored
    cfg_interval = 16'd5;
    respond(32'd1);
    pulse_start();
    chk("R2 start ignored while busy", 32'(rd_req), 32'd0);
    count_low(n);
    chk("R2 R6 remaining gap", 32'(n), 32'd4);

    // R11 abort with read outstanding
    abort = 1'b1;
    step();
    abort = 1'b0;
    chk("R11 waits for outstanding read", {30'd0, busy, rd_req}, 32'd3);
    respond(32'd1);
    chk("R11 ends after read", 32'(busy), 32'd0);
    chk("R11 done set", 32'(done_flag), 32'd1);
    chk("R9 read flag set", 32'(read_flag), 32'd1);

    // R12 start clears done; R9 set wins over clear
    pulse_start();
    chk("R12 start clears done", 32'(done_flag), 32'd0);
    data_rd = 1'b1;
    respond(32'd1);
    data_rd = 1'b1;
    chk("R9 set wins", 32'(read_flag), 32'd1);
    step();
    data_rd = 1'b0;
    chk("R9 cleared by data_rd", 32'(read_flag), 32'd0);
    abort = 1'b1;
    step();
    abort = 1'b0;
    chk("R11 abort in gap", 32'(busy), 32'd0);
    clr_done = 1'b1;
    step();
    clr_done = 1'b0;
    chk("R12 clr_done", 32'(done_flag), 32'd0);

    // R6 zero interval, R7 no auto-stop, R8 set wins
    cfg_len = 2'd0; cfg_mask = 32'hFF; cfg_match = 32'hA5;
    cfg_interval = 16'd0; cfg_auto_stop = 1'b0;
    pulse_start();
    clr_match = 1'b1;
    respond(32'hA5);
    clr_match = 1'b0;
    chk("R8 hit wins over clear", 32'(match_flag), 32'd1);
    chk("R7 continues after hit", 32'(busy), 32'd1);
    chk("R6 zero gap", 32'(rd_req), 32'd1);
    step();
    chk("R8 sticky", 32'(match_flag), 32'd1);
    abort = 1'b1;
    respond(32'd0);
    abort = 1'b0;
    chk("R11 abort with done", 32'(busy), 32'd0);

    // R11 abort while idle has no effect; R9 idle rd_done ignored
    clr_done = 1'b1; data_rd = 1'b1;
    step();
    clr_done = 1'b0; data_rd = 1'b0;
    abort = 1'b1;
    step();
    abort = 1'b0;
    chk("R11 idle abort", {30'd0, busy, done_flag}, 32'd0);
    respond(32'hFFFFFFFF);
    chk("R9 idle rd_done read flag", 32'(read_flag), 32'd0);
    chk("R9 idle rd_done word", status_word, 32'd0);

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule